// File: doc/BRIEF.md
# Folded Symmetric FIR Cell

This block computes one output of a symmetric FIR filter with up to eight taps, using four multipliers. Mirror-image taps share a coefficient, so the two samples that use it are first summed in a pre-adder and then multiplied once. The last eight samples are held in a history line. The newer half forms the forward bank. The older half is read in reverse order as the backward bank, so each forward sample meets the sample it mirrors at the same pre-adder.

A mode input selects even length (eight taps) or odd length (seven taps). In odd mode the backward read is moved by one position. The centre sample then meets itself at the last pre-adder, and that lane's coefficient must be stored at half the centre tap's value. Only the four unique coefficients are kept. They are written through a small indexed write port. A shift enable brings in one new sample. The full-precision sum is registered one clock later and is marked by a one-cycle valid strobe.

The control is a two-state machine. ST_IDLE moves to ST_PEND when shift_en is high and otherwise stays in ST_IDLE. ST_PEND stays in ST_PEND when shift_en is high again and returns to ST_IDLE when it is low. On every clock spent in ST_PEND, the sum of products is loaded into the output register.

Top module: `fsfir_cell`

## Requirements
- R1: While rst_n is low (asynchronous, active low), result is 0 and result_valid is 0. All eight history samples and all four coefficients are cleared to 0.
- R2: A rising clock edge with shift_en high moves every history sample one place older and puts sample_in in the newest place (x0). With shift_en low the history holds, whatever sample_in carries.
- R3: With odd_len = 0, result = C0(x0+x7) + C1(x1+x6) + C2(x2+x5) + C3(x3+x4). Here xk is the sample shifted in k samples before the newest one, x0.
- R4: With odd_len = 1, result = C0(x0+x6) + C1(x1+x5) + C2(x2+x4) + C3(x3+x3). C3 holds half of the centre tap and x7 is unused.
- R5: result_valid is high for exactly one cycle, the second cycle after each shift-enabled edge. result changes only at the edge that raises or keeps result_valid, and otherwise holds.
- R6: A rising edge with coef_we high stores coef_val in coefficient C[coef_idx], with coef_idx 0 to 3 selecting C0 to C3. The new value is used for every output loaded after that edge.
- R7: Samples and coefficients are 10-bit two's complement. result is 23-bit two's complement, and the sum is exact for every input, including all samples at -512 with all coefficients at -512 (result +2097152).
- R8: odd_len and the coefficients are sampled at the edge that loads result, so the sum uses the history as it stands after the shift it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Shift one new sample into the history |
| sample_in | input | 10 | New sample, two's complement |
| odd_len | input | 1 | 1: seven-tap odd mode, 0: eight-tap even mode |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | 2 | Coefficient index, 0 to 3 |
| coef_val | input | 10 | Coefficient value, two's complement |
| result | output | 23 | Registered sum of products |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Single pushes separated by idle gaps show the one-cycle latency and the hold of result. Random sample_in during those gaps, with shift_en low, would show up as a corrupted later sum if the history moved. Back-to-back pushes with random samples and coefficients in both modes tell the odd pairing (x0 with x6, centre doubled) apart from the even pairing (x0 with x7). Because each coefficient is set on its own, a swapped index or a lane that drops out gives a different sum. Extreme values at -512 and +511 expose a sign-extension or width error in the pre-adders, products and adder tree.

// File: rtl/fsfir_pkg.sv
package fsfir_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } fsfir_state_e;
endpackage

// File: rtl/fsfir_history.sv
module fsfir_history #(
    parameter int SAMPLE_W = 10,
    parameter int NUM_MULT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic                       odd_len,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic signed [SAMPLE_W-1:0] fwd_o [NUM_MULT],
    output logic signed [SAMPLE_W-1:0] bwd_o [NUM_MULT]
);
    localparam int TAPS = 2 * NUM_MULT;

    logic signed [SAMPLE_W-1:0] hist_q [TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin
                hist_q[k] <= '0;
            end
        end else if (shift_en) begin
            hist_q[0] <= sample_in;
            for (int k = 1; k < TAPS; k++) begin
                hist_q[k] <= hist_q[k-1];
            end
        end
    end

    // Forward bank: newer half in order. Backward bank: older half reversed,
    // moved by one place in odd mode so the centre sample pairs with itself.
    for (genvar g = 0; g < NUM_MULT; g++) begin : g_fold
        assign fwd_o[g] = hist_q[g];
        assign bwd_o[g] = odd_len ? hist_q[TAPS-2-g] : hist_q[TAPS-1-g];
    end
endmodule

// File: rtl/fsfir_coef_bank.sv
module fsfir_coef_bank #(
    parameter int COEF_W   = 10,
    parameter int NUM_MULT = 4,
    localparam int IDX_W   = $clog2(NUM_MULT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic signed [COEF_W-1:0] val,
    output logic signed [COEF_W-1:0] coef_o [NUM_MULT]
);
    logic signed [COEF_W-1:0] bank_q [NUM_MULT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_MULT; k++) begin
                bank_q[k] <= '0;
            end
        end else if (we) begin
            bank_q[idx] <= val;
        end
    end

    for (genvar g = 0; g < NUM_MULT; g++) begin : g_out
        assign coef_o[g] = bank_q[g];
    end
endmodule

// File: rtl/fsfir_mac.sv
module fsfir_mac #(
    parameter int SAMPLE_W = 10,
    parameter int COEF_W   = 10,
    parameter int NUM_MULT = 4,
    localparam int PRE_W   = SAMPLE_W + 1,
    localparam int PROD_W  = PRE_W + COEF_W,
    localparam int OUT_W   = PROD_W + $clog2(NUM_MULT)
) (
    input  logic signed [SAMPLE_W-1:0] fwd_i  [NUM_MULT],
    input  logic signed [SAMPLE_W-1:0] bwd_i  [NUM_MULT],
    input  logic signed [COEF_W-1:0]   coef_i [NUM_MULT],
    output logic signed [OUT_W-1:0]    sum_o
);
    logic signed [PRE_W-1:0]  pre  [NUM_MULT];
    logic signed [PROD_W-1:0] prod [NUM_MULT];

    for (genvar g = 0; g < NUM_MULT; g++) begin : g_lane
        assign pre[g]  = PRE_W'(fwd_i[g]) + PRE_W'(bwd_i[g]);
        assign prod[g] = PROD_W'(pre[g]) * PROD_W'(coef_i[g]);
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < NUM_MULT; k++) begin
            sum_o = sum_o + OUT_W'(prod[k]);
        end
    end
endmodule

// File: rtl/fsfir_ctrl.sv
module fsfir_ctrl
    import fsfir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    output logic load_o
);
    fsfir_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = shift_en ? ST_PEND : ST_IDLE;
            ST_PEND: state_d = shift_en ? ST_PEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PEND: load_o = 1'b1;
            default: load_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsfir_cell.sv
module fsfir_cell #(
    parameter int SAMPLE_W = 10,
    parameter int COEF_W   = 10,
    parameter int NUM_MULT = 4,
    localparam int IDX_W   = $clog2(NUM_MULT),
    localparam int OUT_W   = SAMPLE_W + 1 + COEF_W + $clog2(NUM_MULT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic                       odd_len,
    input  logic                       coef_we,
    input  logic [IDX_W-1:0]           coef_idx,
    input  logic signed [COEF_W-1:0]   coef_val,
    output logic signed [OUT_W-1:0]    result,
    output logic                       result_valid
);
    logic signed [SAMPLE_W-1:0] fwd  [NUM_MULT];
    logic signed [SAMPLE_W-1:0] bwd  [NUM_MULT];
    logic signed [COEF_W-1:0]   coef [NUM_MULT];
    logic signed [OUT_W-1:0]    sum;
    logic                       load;

    fsfir_history #(.SAMPLE_W(SAMPLE_W), .NUM_MULT(NUM_MULT)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .odd_len(odd_len),
        .sample_in(sample_in), .fwd_o(fwd), .bwd_o(bwd)
    );

    fsfir_coef_bank #(.COEF_W(COEF_W), .NUM_MULT(NUM_MULT)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .idx(coef_idx),
        .val(coef_val), .coef_o(coef)
    );

    fsfir_mac #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .NUM_MULT(NUM_MULT)) u_mac (
        .fwd_i(fwd), .bwd_i(bwd), .coef_i(coef), .sum_o(sum)
    );

    fsfir_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load_o(load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= load;
            if (load) begin
                result <= sum;
            end
        end
    end
endmodule

// File: rtl/fsfir_cell_chk.sv
module fsfir_cell_chk #(
    parameter int OUT_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en,
    input logic [OUT_W-1:0] result,
    input logic             result_valid
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !result_valid));

    a_r5_valid_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> ##2 result_valid);

    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(shift_en, 2));

    a_r5_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));
endmodule

bind fsfir_cell fsfir_cell_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .result(result), .result_valid(result_valid)
);

// File: tb/fsfir_cell_tb_top.sv
module fsfir_cell_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              shift_en = 1'b0;
    logic signed [9:0] sample_in = '0;
    logic              odd_len = 1'b0;
    logic              coef_we = 1'b0;
    logic [1:0]        coef_idx = '0;
    logic signed [9:0] coef_val = '0;
    logic signed [22:0] result;
    logic              result_valid;

    int checks = 0;
    int errors = 0;
    int h [8];
    int c [4];
    longint exp_b [40];

    always #2 clk = ~clk;

    fsfir_cell dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sample_in(sample_in),
        .odd_len(odd_len), .coef_we(coef_we), .coef_idx(coef_idx),
        .coef_val(coef_val), .result(result), .result_valid(result_valid)
    );

    function automatic longint expect_y(input bit odd);
        longint acc = 0;
        for (int i = 0; i < 4; i++) begin
            int partner = odd ? h[6-i] : h[7-i];
            acc += longint'(c[i]) * longint'(h[i] + partner);
        end
        return acc;
    endfunction

    function automatic int rnd_val();
        return int'($urandom_range(1023)) - 512;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_push(input int s);
        for (int k = 7; k > 0; k--) h[k] = h[k-1];
        h[0] = s;
    endtask

    task automatic write_coef(input int idx, input int v);
        @(negedge clk);
        coef_we = 1'b1; coef_idx = 2'(idx); coef_val = 10'(v);
        c[idx] = v;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic push_check(input int s, input string req);
        longint e;
        @(negedge clk);
        shift_en = 1'b1; sample_in = 10'(s);
        model_push(s);
        e = expect_y(odd_len);
        @(negedge clk);
        shift_en = 1'b0; sample_in = 10'(rnd_val());
        check(result_valid == 1'b0, "R5 valid early", longint'(result_valid), 0);
        @(negedge clk);
        check(result_valid == 1'b1, "R5 valid strobe", longint'(result_valid), 1);
        check(longint'(result) == e, req, longint'(result), e);
        @(negedge clk);
        check(result_valid == 1'b0 && longint'(result) == e, "R5 hold after strobe",
              longint'(result), e);
    endtask

    task automatic idle_gap(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            shift_en = 1'b0; sample_in = 10'(rnd_val());
            check(result_valid == 1'b0, "R2 no valid while held", longint'(result_valid), 0);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) h[k] = 0;
        for (int k = 0; k < 4; k++) c[k] = 0;
        repeat (3) @(negedge clk);
        check(result == '0, "R1 reset result", longint'(result), 0);
        check(result_valid == 1'b0, "R1 reset valid", longint'(result_valid), 0);
        rst_n = 1'b1;
        // R1: cleared coefficients give zero for any sample
        push_check(300, "R1 zero coefs");

        // R6: one coefficient at a time exposes each index and lane
        write_coef(0, 1);
        push_check(5, "R6 C0 lane even R3");
        write_coef(0, 0); write_coef(3, 2);
        push_check(-7, "R6 C3 lane even R3");
        write_coef(3, 0); write_coef(2, -3);
        push_check(11, "R6 C2 lane R3");
        write_coef(1, 4);
        odd_len = 1'b1;
        push_check(-100, "R4 odd pairing");
        odd_len = 1'b0;

        // R7: extremes
        for (int k = 0; k < 4; k++) write_coef(k, -512);
        for (int k = 0; k < 8; k++) push_check(-512, "R7 min extremes");
        check(longint'(result) == 64'sd2097152, "R7 full scale", longint'(result), 2097152);
        for (int k = 0; k < 8; k++) push_check(511, "R7 max sample min coef");
        odd_len = 1'b1;
        push_check(511, "R7 R4 odd extremes");
        odd_len = 1'b0;

        // R2 + random rounds with both modes and idle gaps
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 4; k++) write_coef(k, rnd_val());
            odd_len = r[0];
            for (int j = 0; j < 5; j++) begin
                push_check(rnd_val(), odd_len ? "R4 random odd" : "R3 random even");
                idle_gap(int'($urandom_range(3)));
            end
        end

        // R8 + R5: back-to-back shifts, result tracks every sample
        for (int i = 0; i < 42; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check(result_valid == 1'b1, "R5 burst valid", longint'(result_valid), 1);
                check(longint'(result) == exp_b[i-2], "R8 burst result",
                      longint'(result), exp_b[i-2]);
            end
            if (i < 40) begin
                int s = rnd_val();
                shift_en = 1'b1; sample_in = 10'(s);
                model_push(s);
                exp_b[i] = expect_y(odd_len);
            end else begin
                shift_en = 1'b0;
            end
        end
        @(negedge clk);
        check(result_valid == 1'b0, "R5 burst end", longint'(result_valid), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule